// File: doc/BRIEF.md
# Data-Space Memory Router

This block sits between a processor's data-move port and its memories. Every data access carries a 16-bit address into a 64 KB data space. The block decides whether the access goes to a 1024-byte read/write buffer inside the block or to an external bus. That buffer is held as a plain register array. Instruction fetches and the 256-byte scratchpad use other paths and never reach this block.

A single enable bit, loaded through a configuration strobe, decides where the bottom kilobyte lives. While the bit is clear, the whole space from 0000h to FFFFh goes to the external bus. While it is set, 0000h to 03FFh is served on chip in one cycle and every other address goes out. The bit is cleared by reset. Toggling it only remaps addresses and never disturbs what the on-chip buffer holds.

An external access raises a request and keeps address, direction and write data steady until the bus acknowledges. The router picks the data source when it accepts the access, and that choice holds even if the enable bit changes while the access is in flight.

Top module: `xdata_router`

## Requirements
- R1: After reset the enable bit is clear, `acc_done` is low and `ext_req` is low.
- R2: While the enable bit is clear, every access, including addresses 0000h to 03FFh, raises `ext_req` in the cycle after the strobe edge and never touches the on-chip buffer.
- R3: While the enable bit is set, an access to 0000h to 03FFh is served on chip. `acc_done` is high in the cycle right after the strobe edge, `ext_req` stays low, and a write updates the buffer byte at the low 10 address bits.
- R4: While the enable bit is set, an access to 0400h to FFFFh goes to the external bus.
- R5: Once raised, `ext_req` stays high with `ext_addr`, `ext_we` and `ext_wdata` unchanged until `ext_ack` is sampled high. In the cycle after that, `ext_req` is low and `acc_done` is high.
- R6: `acc_rdata` in a read's `acc_done` cycle holds the byte from the route chosen when the read was accepted. For an on-chip read that is the buffer byte; for an external read it is `ext_rdata` as sampled with `ext_ack`.
- R7: A configuration write (`cfg_wr` high) loads `cfg_en` into the enable bit at that clock edge. An access strobed in the same cycle still uses the old value.
- R8: Clearing and setting the enable bit leaves the on-chip buffer unchanged. After re-enabling, a read returns the byte last written on chip.
- R9: Strobes presented while an external access is pending are ignored. They produce no `acc_done`, do not change `ext_addr`, and do not write the buffer.
- R10: When `acc_rd` and `acc_wr` are both high, the access is a write. `ext_we` is 1 for external writes and 0 for external reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the enable bit |
| cfg_en | input | 1 | New enable value, 1 maps the low 1 KB on chip |
| acc_rd | input | 1 | Read strobe, one cycle |
| acc_wr | input | 1 | Write strobe, one cycle |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with acc_done after a read |
| acc_done | output | 1 | One-cycle completion pulse |
| ext_req | output | 1 | External access request |
| ext_we | output | 1 | External direction, 1 means write |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External acknowledge |
| ext_rdata | input | 8 | External read data, sampled with ext_ack |

## Verification
An on-chip access completes with `acc_done` one cycle after its strobe edge. An external access shows `ext_req` one cycle after its strobe edge, and `acc_done` comes one cycle after the edge that samples `ext_ack`. The bench drives every input on the falling edge and samples every output on the next falling edge after the edge that should produce it. At each of those points it compares against a reference model of the enable bit, the on-chip bytes and the external memory. While it holds off the acknowledge for a random number of cycles, it checks that the request stays up and no completion appears, and in one directed case it slips in a stray strobe at that point.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXT  = 1'b1
    } xdr_state_e;
endpackage

// File: rtl/xdr_mode.sv
module xdr_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_en,
    output logic en
);
    typedef struct packed {
        logic en;
    } mode_s;

    mode_s mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (cfg_wr) begin
            mode_d.en = cfg_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign en = mode_q.en;

    // R7
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> en == $past(cfg_en));

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(en));
endmodule

// File: rtl/xdr_decode.sv
module xdr_decode #(
    parameter int ADDR_W    = 16,
    parameter int INT_DEPTH = 1024,
    localparam int INT_AW   = $clog2(INT_DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic              hit,
    output logic [INT_AW-1:0] int_addr
);
    logic upper_zero;

    always_comb begin
        upper_zero = (addr[ADDR_W-1:INT_AW] == '0);
        hit        = en && upper_zero;
        int_addr   = addr[INT_AW-1:0];
    end
endmodule

// File: rtl/xdr_sram.sv
module xdr_sram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/xdr_ctrl.sv
module xdr_ctrl
    import xdr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              hit,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              sram_we,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_done,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata
);
    typedef struct packed {
        xdr_state_e        state;
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  start;
    logic  idle;

    always_comb begin
        ctrl_d  = ctrl_q;
        sram_we = 1'b0;
        start   = acc_rd || acc_wr;
        idle    = (ctrl_q.state == ST_IDLE);
        ctrl_d.done = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (hit) begin
                        sram_we     = acc_wr;
                        ctrl_d.done = 1'b1;
                        if (!acc_wr) begin
                            ctrl_d.rdata = sram_rdata;
                        end
                    end else begin
                        ctrl_d.state = ST_EXT;
                        ctrl_d.req   = 1'b1;
                        ctrl_d.we    = acc_wr;
                        ctrl_d.addr  = acc_addr;
                        ctrl_d.wdata = acc_wdata;
                    end
                end
            end
            ST_EXT: begin
                if (ext_ack) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.req   = 1'b0;
                    ctrl_d.done  = 1'b1;
                    if (!ctrl_q.we) begin
                        ctrl_d.rdata = ext_rdata;
                    end
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign acc_rdata = ctrl_q.rdata;
    assign acc_done  = ctrl_q.done;
    assign ext_req   = ctrl_q.req;
    assign ext_we    = ctrl_q.we;
    assign ext_addr  = ctrl_q.addr;
    assign ext_wdata = ctrl_q.wdata;

    // R3
    int_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle && start && hit |=> acc_done && !ext_req);

    // R2
    ext_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle && start && !hit |=> ext_req && !acc_done && ext_addr == $past(acc_addr));

    // R5
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_we) && $stable(ext_wdata));

    // R5
    ext_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_ack |=> !ext_req && acc_done);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_ack |=> !acc_done);

    // R10
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> !ext_req);
endmodule

// File: rtl/xdata_router.sv
module xdata_router #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int INT_DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_done,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata
);
    localparam int INT_AW = $clog2(INT_DEPTH);

    logic              en;
    logic              hit;
    logic [INT_AW-1:0] int_addr;
    logic              sram_we;
    logic [DATA_W-1:0] sram_rdata;

    xdr_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr),
        .cfg_en (cfg_en),
        .en     (en)
    );

    xdr_decode #(
        .ADDR_W    (ADDR_W),
        .INT_DEPTH (INT_DEPTH)
    ) u_decode (
        .addr     (acc_addr),
        .en       (en),
        .hit      (hit),
        .int_addr (int_addr)
    );

    xdr_sram #(
        .DATA_W (DATA_W),
        .DEPTH  (INT_DEPTH)
    ) u_sram (
        .clk   (clk),
        .we    (sram_we),
        .addr  (int_addr),
        .wdata (acc_wdata),
        .rdata (sram_rdata)
    );

    xdr_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .hit        (hit),
        .sram_rdata (sram_rdata),
        .sram_we    (sram_we),
        .ext_ack    (ext_ack),
        .ext_rdata  (ext_rdata),
        .acc_rdata  (acc_rdata),
        .acc_done   (acc_done),
        .ext_req    (ext_req),
        .ext_we     (ext_we),
        .ext_addr   (ext_addr),
        .ext_wdata  (ext_wdata)
    );

    // R4
    high_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr >= ADDR_W'(INT_DEPTH)) |-> !hit);
endmodule

// File: tb/xdata_router_tb.sv
module xdata_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_en = 1'b0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic        acc_done;
    logic        ext_req;
    logic        ext_we;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic        ext_ack = 1'b0;
    logic [7:0]  ext_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] ref_int [1024];
    logic [7:0] ext_mem [int];
    bit         ref_en = 1'b0;

    always #10 clk = ~clk;

    xdata_router u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_en    (cfg_en),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .acc_done  (acc_done),
        .ext_req   (ext_req),
        .ext_we    (ext_we),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_ack   (ext_ack),
        .ext_rdata (ext_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ext_val(input logic [15:0] a);
        if (ext_mem.exists(int'(a))) return ext_mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic set_en(input bit v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_en = v;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        ref_en = v;
    endtask

    // cfg_same: also write the enable bit in the strobe cycle (R7)
    // inject: present a stray write to on-chip byte 5 while waiting (R9)
    task automatic access(input bit wr, input bit both, input logic [15:0] a,
                          input logic [7:0] d, input bit cfg_same, input bit cfg_v,
                          input bit inject);
        bit         exp_int;
        int         dly;
        logic [7:0] exp_rd;
        exp_int = ref_en && (a < 16'h0400);
        @(negedge clk);
        acc_addr  = a;
        acc_wdata = d;
        acc_wr    = wr;
        acc_rd    = !wr || both;
        if (cfg_same) begin
            cfg_wr = 1'b1;
            cfg_en = cfg_v;
        end
        @(posedge clk);
        @(negedge clk);
        acc_wr = 1'b0;
        acc_rd = 1'b0;
        cfg_wr = 1'b0;
        if (cfg_same) ref_en = cfg_v;
        if (exp_int) begin
            chk(acc_done == 1'b1, "R3 on-chip done", int'(acc_done), 1);
            chk(ext_req == 1'b0, "R3 no ext_req", int'(ext_req), 0);
            if (wr) begin
                ref_int[a[9:0]] = d;
            end else begin
                chk(acc_rdata == ref_int[a[9:0]], "R6 on-chip rdata", int'(acc_rdata), int'(ref_int[a[9:0]]));
            end
        end else begin
            chk(ext_req == 1'b1, ref_en ? "R4 ext_req" : "R2 ext_req", int'(ext_req), 1);
            chk(acc_done == 1'b0, "R5 no early done", int'(acc_done), 0);
            chk(ext_addr == a, "R5 ext_addr", int'(ext_addr), int'(a));
            chk(ext_we == wr, "R10 ext_we", int'(ext_we), int'(wr));
            if (wr) chk(ext_wdata == d, "R5 ext_wdata", int'(ext_wdata), int'(d));
            dly = inject ? 2 : int'($urandom % 4);
            for (int i = 0; i < dly; i++) begin
                if (inject && i == 0) begin
                    acc_addr  = 16'h0005;
                    acc_wdata = 8'hEE;
                    acc_wr    = 1'b1;
                end
                @(posedge clk);
                @(negedge clk);
                acc_wr = 1'b0;
                chk(ext_req == 1'b1, "R5 req held", int'(ext_req), 1);
                chk(ext_addr == a, inject ? "R9 ext_addr kept" : "R5 addr held", int'(ext_addr), int'(a));
                chk(acc_done == 1'b0, inject ? "R9 no done" : "R5 no done", int'(acc_done), 0);
            end
            ext_ack   = 1'b1;
            exp_rd    = ext_val(a);
            ext_rdata = exp_rd;
            @(posedge clk);
            @(negedge clk);
            ext_ack   = 1'b0;
            ext_rdata = 8'h00;
            chk(acc_done == 1'b1, "R5 done after ack", int'(acc_done), 1);
            chk(ext_req == 1'b0, "R5 req dropped", int'(ext_req), 0);
            if (wr) ext_mem[int'(a)] = d;
            else chk(acc_rdata == exp_rd, "R6 ext rdata", int'(acc_rdata), int'(exp_rd));
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) ref_int[i] = 8'h00;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(acc_done == 1'b0, "R1 done low", int'(acc_done), 0);
        chk(ext_req == 1'b0, "R1 req low", int'(ext_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_req == 1'b0, "R1 req low after release", int'(ext_req), 0);
        // R1 R2: enable clear after reset, low addresses go external
        access(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0);
        access(1'b1, 1'b0, 16'h03FF, 8'h77, 1'b0, 1'b0, 1'b0);
        // R3: enable and fill on-chip bytes at both ends
        set_en(1'b1);
        for (int i = 0; i < 1024; i += 73) access(1'b1, 1'b0, 16'(i), 8'(i * 3 + 1), 1'b0, 1'b0, 1'b0);
        access(1'b1, 1'b0, 16'h0000, 8'hA1, 1'b0, 1'b0, 1'b0);
        access(1'b1, 1'b0, 16'h03FF, 8'hB2, 1'b0, 1'b0, 1'b0);
        access(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0);
        access(1'b0, 1'b0, 16'h03FF, 8'h00, 1'b0, 1'b0, 1'b0);
        // R4: boundary and top
        access(1'b1, 1'b0, 16'h0400, 8'hC3, 1'b0, 1'b0, 1'b0);
        access(1'b0, 1'b0, 16'h0400, 8'h00, 1'b0, 1'b0, 1'b0);
        access(1'b0, 1'b0, 16'hFFFF, 8'h00, 1'b0, 1'b0, 1'b0);
        // R10: both strobes high is a write
        access(1'b1, 1'b1, 16'h0010, 8'h3C, 1'b0, 1'b0, 1'b0);
        access(1'b0, 1'b0, 16'h0010, 8'h00, 1'b0, 1'b0, 1'b0);
        // R9: stray strobe during pending external access leaves byte 5 alone
        access(1'b1, 1'b0, 16'h0005, 8'h11, 1'b0, 1'b0, 1'b0);
        access(1'b0, 1'b0, 16'h2345, 8'h00, 1'b0, 1'b0, 1'b1);
        access(1'b0, 1'b0, 16'h0005, 8'h00, 1'b0, 1'b0, 1'b0);
        // R8: disable shows external data, re-enable shows old on-chip data
        set_en(1'b0);
        access(1'b0, 1'b0, 16'h03FF, 8'h00, 1'b0, 1'b0, 1'b0);
        set_en(1'b1);
        access(1'b0, 1'b0, 16'h03FF, 8'h00, 1'b0, 1'b0, 1'b0);
        // R7: config write in the strobe cycle affects the next access only
        access(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0);
        access(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b1, 1'b0);
        access(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0);
        // random mix
        for (int n = 0; n < 400; n++) begin
            int          sel;
            logic [15:0] a;
            sel = int'($urandom % 4);
            if (sel < 2) a = 16'($urandom % 1024);
            else if (sel == 2) a = 16'h03F0 + 16'($urandom % 32);
            else a = 16'($urandom);
            if ($urandom % 10 == 0) set_en(1'($urandom));
            access(1'($urandom), 1'b0, a, 8'($urandom), 1'b0, 1'b0, 1'b0);
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule